// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the settings of a phase-locked loop, given its reference frequency and the frequency wanted at the VCO. Both frequencies come in as unsigned integers in hertz. After a start pulse, the engine steps the input divider N across every value that keeps the phase-detector comparison frequency inside its allowed window. For each N it works out a feedback divider M, forces M to an even value, and computes the VCO frequency that M and N give. It keeps the candidate whose VCO frequency lies closest to the target.

A single shared sequential divider does all the integer division, one multi-cycle divide per stage. The engine passes through these states in order:
- `S_IDLE` goes to `S_NLO` on start.
- `S_NLO` computes the lowest N, then goes to `S_NHI`.
- `S_NHI` computes the highest N, then goes to `S_MDIV`. If the range is empty it goes straight to `S_DONE`.
- `S_MDIV` computes M. It goes to `S_VDIV` if M is in range, and otherwise to `S_NEXT`.
- `S_VDIV` computes the VCO frequency, then goes to `S_EVAL`.
- `S_EVAL` checks the limits and tracks the best candidate, then goes to `S_NEXT`.
- `S_NEXT` moves to the next N and returns to `S_MDIV`. After the last N it goes to `S_DONE`.
- `S_DONE` pulses `done`, then returns to `S_IDLE`.

A start pulse is only accepted in `S_IDLE`. The results stay on the outputs until the next accepted start.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0, and `best_n`, `best_m` and `best_freq_hz` are 0.
- R2: N runs from ceil(Fref / 40 MHz) to floor(Fref / 5 MHz), and never below 1. If this range is empty (Fref below 5 MHz, or zero), the search reports not found.
- R3: For each N, M = floor(Fout*N / Fref). If M is below 6 or above 512, that N is skipped.
- R4: An odd M is raised by one, so every reported M is even.
- R5: The VCO frequency is floor(M*Fref / N). The candidate is rejected if this is below 80 MHz or above 1500 MHz. Both limits are inclusive.
- R6: The result is the accepted candidate with the smallest |Fout - Fvco|. On a tie, the smaller N is kept.
- R7: `done` is high for exactly one cycle at the end of the search. `busy` is high from the cycle after an accepted start through the `done` cycle. The outputs do not change while the engine is idle.
- R8: When no candidate is accepted, `found` is 0, and `best_n`, `best_m` and `best_freq_hz` are 0 at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted while idle |
| fref_hz | input | 32 | Reference frequency in Hz, captured at start |
| fout_hz | input | 32 | Target VCO frequency in Hz, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A candidate was accepted |
| best_n | output | 10 | Selected input divider |
| best_m | output | 10 | Selected even feedback divider |
| best_freq_hz | output | 32 | VCO frequency achieved by the selected pair |

## Verification
Some properties of the result are checked on every cycle by assertions:
- A reported pair always has an even M between 6 and 512.
- Its frequency lies inside the VCO window.
- Its N satisfies both comparison-frequency bounds against the reference captured at start.
- A failed search reports zeros.
- `done` is a single pulse, `busy` rises only after a start, and the outputs do not move while idle.

Other behaviours can only be shown by the bench's scenarios with known answers. These are:
- that the chosen pair is the closest one;
- that ties keep the smaller N;
- that an M below 6 is skipped even when it would hit the target exactly;
- that odd values of M are rounded upward;
- that the lowest N really starts at ceil(Fref / 40 MHz).

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_NLO,
        S_NHI,
        S_MDIV,
        S_VDIV,
        S_EVAL,
        S_NEXT,
        S_DONE
    } search_state_t;
endpackage

// File: rtl/pll_seq_div.sv
// Restoring divider: one quotient bit per cycle, W cycles per divide.
module pll_seq_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic [W:0]    shifted;
    logic          take;

    assign shifted = {rem_q, quo_q[W-1]};
    assign take    = (shifted >= {1'b0, den});
    assign quo     = quo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quo_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
        end else if (go) begin
            rem_q    <= '0;
            quo_q    <= num;
            cnt_q    <= CW'(W);
            active_q <= 1'b1;
            done     <= 1'b0;
        end else if (active_q) begin
            if (take) begin
                rem_q <= W'(shifted - {1'b0, den});
            end else begin
                rem_q <= shifted[W-1:0];
            end
            quo_q <= {quo_q[W-2:0], take};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                active_q <= 1'b0;
                done     <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_cand_eval.sv
// Combinational candidate checks: M window, even rounding, VCO window, distance.
module pll_cand_eval #(
    parameter int FREQ_W    = 32,
    parameter int M_W       = 10,
    parameter int M_LO      = 6,
    parameter int M_HI      = 512,
    parameter longint VCO_LO_HZ = 80_000_000,
    parameter longint VCO_HI_HZ = 1_500_000_000
) (
    input  logic [2*FREQ_W-1:0] m_raw,
    input  logic [2*FREQ_W-1:0] fvco,
    input  logic [FREQ_W-1:0]   fout,
    output logic                m_ok,
    output logic [M_W-1:0]      m_even,
    output logic                vco_ok,
    output logic [2*FREQ_W-1:0] delta
);
    localparam int PW = 2 * FREQ_W;

    logic [PW-1:0] fout_w;

    assign fout_w = PW'(fout);
    assign m_ok   = (m_raw >= PW'(M_LO)) && (m_raw <= PW'(M_HI));
    assign m_even = m_raw[M_W-1:0] + M_W'(m_raw[0]);
    assign vco_ok = (fvco >= PW'(VCO_LO_HZ)) && (fvco <= PW'(VCO_HI_HZ));

    always_comb begin
        if (fvco > fout_w) begin
            delta = fvco - fout_w;
        end else begin
            delta = fout_w - fvco;
        end
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int     FREQ_W     = 32,
    parameter int     N_W        = 10,
    parameter int     M_W        = 10,
    parameter longint PFD_MAX_HZ = 40_000_000,
    parameter longint PFD_MIN_HZ = 5_000_000,
    parameter int     M_LO       = 6,
    parameter int     M_HI       = 512,
    parameter longint VCO_LO_HZ  = 80_000_000,
    parameter longint VCO_HI_HZ  = 1_500_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] fref_hz,
    input  logic [FREQ_W-1:0] fout_hz,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [N_W-1:0]    best_n,
    output logic [M_W-1:0]    best_m,
    output logic [FREQ_W-1:0] best_freq_hz
);
    localparam int PW = 2 * FREQ_W;

    search_state_t state, state_nx;

    logic [FREQ_W-1:0] fref_q, fout_q;
    logic [N_W-1:0]    n_lo, n_hi, n_cur, n_first;
    logic [M_W-1:0]    m_cand;
    logic [PW-1:0]     fvco_q;
    logic [PW-1:0]     best_delta;
    logic              launch, launch_nx;

    logic [PW-1:0]     div_num, div_den, div_q;
    logic              div_done;

    logic              m_ok, vco_ok;
    logic [M_W-1:0]    m_even;
    logic [PW-1:0]     delta;

    assign n_first = (n_lo == '0) ? N_W'(1) : n_lo;

    // Operand selection follows the state that owns the divider.
    always_comb begin
        div_num = '0;
        div_den = PW'(1);
        unique case (state)
            S_NLO: begin
                div_num = PW'(fref_q) + PW'(PFD_MAX_HZ - 1);
                div_den = PW'(PFD_MAX_HZ);
            end
            S_NHI: begin
                div_num = PW'(fref_q);
                div_den = PW'(PFD_MIN_HZ);
            end
            S_MDIV: begin
                div_num = PW'(fout_q) * PW'(n_cur);
                div_den = PW'(fref_q);
            end
            S_VDIV: begin
                div_num = PW'(m_cand) * PW'(fref_q);
                div_den = PW'(n_cur);
            end
            default: ;
        endcase
    end

    pll_seq_div #(.W(PW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (launch),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_q),
        .done  (div_done)
    );

    pll_cand_eval #(
        .FREQ_W    (FREQ_W),
        .M_W       (M_W),
        .M_LO      (M_LO),
        .M_HI      (M_HI),
        .VCO_LO_HZ (VCO_LO_HZ),
        .VCO_HI_HZ (VCO_HI_HZ)
    ) u_eval (
        .m_raw  (div_q),
        .fvco   (fvco_q),
        .fout   (fout_q),
        .m_ok   (m_ok),
        .m_even (m_even),
        .vco_ok (vco_ok),
        .delta  (delta)
    );

    // Next state and divider launch.
    always_comb begin
        state_nx  = state;
        launch_nx = 1'b0;
        unique case (state)
            S_IDLE: if (start) begin
                state_nx  = S_NLO;
                launch_nx = 1'b1;
            end
            S_NLO: if (div_done) begin
                state_nx  = S_NHI;
                launch_nx = 1'b1;
            end
            S_NHI: if (div_done) begin
                if (div_q < PW'(n_first)) begin
                    state_nx = S_DONE;
                end else begin
                    state_nx  = S_MDIV;
                    launch_nx = 1'b1;
                end
            end
            S_MDIV: if (div_done) begin
                if (m_ok) begin
                    state_nx  = S_VDIV;
                    launch_nx = 1'b1;
                end else begin
                    state_nx = S_NEXT;
                end
            end
            S_VDIV: if (div_done) state_nx = S_EVAL;
            S_EVAL: state_nx = S_NEXT;
            S_NEXT: begin
                if (n_cur >= n_hi) begin
                    state_nx = S_DONE;
                end else begin
                    state_nx  = S_MDIV;
                    launch_nx = 1'b1;
                end
            end
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch       <= 1'b0;
            fref_q       <= '0;
            fout_q       <= '0;
            n_lo         <= '0;
            n_hi         <= '0;
            n_cur        <= '0;
            m_cand       <= '0;
            fvco_q       <= '0;
            best_delta   <= '1;
            best_n       <= '0;
            best_m       <= '0;
            best_freq_hz <= '0;
            found        <= 1'b0;
        end else begin
            launch <= launch_nx;
            unique case (state)
                S_IDLE: if (start) begin
                    fref_q       <= fref_hz;
                    fout_q       <= fout_hz;
                    best_delta   <= '1;
                    best_n       <= '0;
                    best_m       <= '0;
                    best_freq_hz <= '0;
                    found        <= 1'b0;
                end
                S_NLO: if (div_done) n_lo <= div_q[N_W-1:0];
                S_NHI: if (div_done) begin
                    n_hi  <= div_q[N_W-1:0];
                    n_cur <= n_first;
                end
                S_MDIV: if (div_done) m_cand <= m_even;
                S_VDIV: if (div_done) fvco_q <= div_q;
                S_EVAL: if (vco_ok && (delta < best_delta)) begin
                    best_delta   <= delta;
                    best_n       <= n_cur;
                    best_m       <= m_cand;
                    best_freq_hz <= fvco_q[FREQ_W-1:0];
                    found        <= 1'b1;
                end
                S_NEXT: if (n_cur < n_hi) n_cur <= n_cur + N_W'(1);
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int     FREQ_W     = 32,
    parameter int     N_W        = 10,
    parameter int     M_W        = 10,
    parameter longint PFD_MAX_HZ = 40_000_000,
    parameter longint PFD_MIN_HZ = 5_000_000,
    parameter int     M_LO       = 6,
    parameter int     M_HI       = 512,
    parameter longint VCO_LO_HZ  = 80_000_000,
    parameter longint VCO_HI_HZ  = 1_500_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [FREQ_W-1:0] fref_hz,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic [N_W-1:0]    best_n,
    input logic [M_W-1:0]    best_m,
    input logic [FREQ_W-1:0] best_freq_hz
);
    localparam int PW = 2 * FREQ_W;

    logic [FREQ_W-1:0] ref_cap;
    logic [PW-1:0]     n_lo_prod, n_hi_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cap <= '0;
        end else if (start && !busy) begin
            ref_cap <= fref_hz;
        end
    end

    assign n_lo_prod = PW'(best_n) * PW'(PFD_MIN_HZ);
    assign n_hi_prod = PW'(best_n) * PW'(PFD_MAX_HZ);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(best_n) && $stable(best_m)
                                     && $stable(best_freq_hz) && $stable(found)));
    a_r4_even_m: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> !best_m[0]);
    a_r3_m_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (best_m >= M_W'(M_LO)) && (best_m <= M_W'(M_HI)));
    a_r5_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (PW'(best_freq_hz) >= PW'(VCO_LO_HZ))
                            && (PW'(best_freq_hz) <= PW'(VCO_HI_HZ)));
    a_r2_n_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (best_n != '0) && (n_lo_prod <= PW'(ref_cap))
                            && (n_hi_prod >= PW'(ref_cap)));
    a_r8_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (best_n == '0) && (best_m == '0) && (best_freq_hz == '0));
endmodule

bind pll_div_search pll_div_search_chk #(
    .FREQ_W     (FREQ_W),
    .N_W        (N_W),
    .M_W        (M_W),
    .PFD_MAX_HZ (PFD_MAX_HZ),
    .PFD_MIN_HZ (PFD_MIN_HZ),
    .M_LO       (M_LO),
    .M_HI       (M_HI),
    .VCO_LO_HZ  (VCO_LO_HZ),
    .VCO_HI_HZ  (VCO_HI_HZ)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .fref_hz      (fref_hz),
    .busy         (busy),
    .done         (done),
    .found        (found),
    .best_n       (best_n),
    .best_m       (best_m),
    .best_freq_hz (best_freq_hz)
);

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    typedef struct packed {
        logic [31:0] fref;
        logic [31:0] fout;
        logic        fnd;
        logic [9:0]  n;
        logic [9:0]  m;
        logic [31:0] f;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'd24000000, 32'd1000000000, 1'b1, 10'd4, 10'd166, 32'd996000000},
        '{32'd24000000, 32'd48000000,   1'b0, 10'd0, 10'd0,   32'd0},
        '{32'd3000000,  32'd100000000,  1'b0, 10'd0, 10'd0,   32'd0},
        '{32'd10000000, 32'd100000000,  1'b1, 10'd1, 10'd10,  32'd100000000},
        '{32'd24000000, 32'd1500000000, 1'b1, 10'd4, 10'd250, 32'd1500000000},
        '{32'd40000000, 32'd120000000,  1'b1, 10'd2, 10'd6,   32'd120000000},
        '{32'd5000000,  32'd105000000,  1'b1, 10'd1, 10'd22,  32'd110000000},
        '{32'd5000000,  32'd80000000,   1'b1, 10'd1, 10'd16,  32'd80000000},
        '{32'd5000000,  32'd74000000,   1'b0, 10'd0, 10'd0,   32'd0},
        '{32'd80000000, 32'd960000000,  1'b1, 10'd2, 10'd24,  32'd960000000},
        '{32'd0,        32'd100000000,  1'b0, 10'd0, 10'd0,   32'd0}
    };

    string vreq [NVEC] = '{"R6", "R8", "R2", "R6", "R5", "R3", "R4", "R5", "R5", "R2", "R2"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fref_hz = '0;
    logic [31:0] fout_hz = '0;
    logic        busy, done, found;
    logic [9:0]  best_n, best_m;
    logic [31:0] best_freq_hz;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_div_search u_pll_div_search (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fref_hz      (fref_hz),
        .fout_hz      (fout_hz),
        .busy         (busy),
        .done         (done),
        .found        (found),
        .best_n       (best_n),
        .best_m       (best_m),
        .best_freq_hz (best_freq_hz)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_search(input logic [31:0] fr, input logic [31:0] fo,
                              output bit ok);
        @(negedge clk);
        fref_hz = fr;
        fout_hz = fo;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) begin
            check("R7", "search timeout", 0, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog expired: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", longint'(busy), 0);
        check("R1", "done", longint'(done), 0);
        check("R1", "found", longint'(found), 0);
        check("R1", "best_n", longint'(best_n), 0);
        check("R1", "best_freq", longint'(best_freq_hz), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_search(VECS[v].fref, VECS[v].fout, ok);
            if (ok) begin
                check(vreq[v], $sformatf("vec%0d found", v), longint'(found), longint'(VECS[v].fnd));
                check(vreq[v], $sformatf("vec%0d best_n", v), longint'(best_n), longint'(VECS[v].n));
                check(vreq[v], $sformatf("vec%0d best_m", v), longint'(best_m), longint'(VECS[v].m));
                check(vreq[v], $sformatf("vec%0d freq", v), longint'(best_freq_hz), longint'(VECS[v].f));
            end
        end

        // R7: single done pulse, busy drops, results hold while idle
        run_search(32'd24000000, 32'd1000000000, ok);
        @(negedge clk);
        check("R7", "done after pulse", longint'(done), 0);
        check("R7", "busy after done", longint'(busy), 0);
        fref_hz = 32'd5000000;
        fout_hz = 32'd74000000;
        repeat (5) @(negedge clk);
        check("R7", "held n", longint'(best_n), 4);
        check("R7", "held m", longint'(best_m), 166);
        check("R7", "held found", longint'(found), 1);

        // R8: a failing search after a good one clears the outputs
        run_search(32'd24000000, 32'd48000000, ok);
        check("R8", "cleared m", longint'(best_m), 0);
        check("R8", "cleared freq", longint'(best_freq_hz), 0);

        // R1: reset mid-search returns to idle state
        @(negedge clk);
        fref_hz = 32'd24000000;
        fout_hz = 32'd1000000000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "busy in reset", longint'(busy), 0);
        check("R1", "found in reset", longint'(found), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule